// File: doc/BRIEF.md
# Path-Indexed Loop Predictor

This block predicts, ahead of fetch, whether a branch closes a loop and how that loop will behave. It keeps a short shift register of recent conditional-branch outcomes. It folds that history into the branch address to select one entry of a loop table. A matching entry returns four things: the loop's first and last instruction addresses, how many iterations the loop is expected to run, and a pointer into a second, smaller table. That second table holds a chain of per-iteration branch patterns. Each link carries a 3-bit outcome pattern, a mask of which pattern bits are meaningful, how many consecutive iterations follow that pattern, and a pointer to the next link.

A lookup is answered two cycles after it is accepted. A hit whose confidence is high enough also emits the first link of its pattern chain one cycle later. The block then waits in a walking state, where each step request returns the following link until the chain ends. When a loop exits, the front end writes the observed values back through an update port, using the history value it saved at lookup time. Chain links are written through their own port.

The controller has four states. `ST_IDLE` waits for a lookup. `ST_TAG` compares the tag, answers the lookup, and stalls while an update is presented. `ST_PATH` emits the first chain link. `ST_CHAIN` serves step requests or accepts a new lookup. The transitions are:
- lookup accepted: `ST_IDLE` to `ST_TAG`, or `ST_CHAIN` to `ST_TAG`.
- update stall: `ST_TAG` stays in `ST_TAG`.
- confident hit: `ST_TAG` to `ST_PATH`.
- miss or low confidence: `ST_TAG` to `ST_IDLE`.
- first link sent: `ST_PATH` to `ST_CHAIN`.
- chain end: `ST_CHAIN` to `ST_IDLE`.

Top module: `loop_path_predictor`

## Requirements
- R1: `path_hist` shifts left by one on each cycle with `br_valid` high, taking `br_taken` into bit 0. Without `br_valid` it holds. It resets to zero.
- R2: A lookup is accepted when `lk_valid` is high and `lk_ready` is high. It selects entry `lk_pc[7:2] XOR path_hist`. It hits when that entry has been written and its stored tag equals `{lk_pc[31:8], lk_pc[1:0]}`. `rsp_valid` pulses for one cycle, two clock edges after the accepting edge.
- R3: On a miss, `rsp_hit` and `rsp_cache` are 0. `rsp_head`, `rsp_tail`, `rsp_iters`, `rsp_ptr` and `rsp_conf` are 0. No chain link is emitted.
- R4: `rsp_cache` is 1 exactly when the response is a hit and `rsp_iters` is greater than 1.
- R5: An update selects entry `up_pc[7:2] XOR up_hist` and tag `{up_pc[31:8], up_pc[1:0]}`. If that entry holds this tag, its addresses, iteration count and pointer are overwritten. Its 2-bit confidence goes up by one when `up_path_ok` is 1 and down by one when it is 0, saturating at 3 and at 0.
- R6: An update to an entry that was never written, or that holds another tag, installs the new loop with confidence 0.
- R7: A hit with confidence of 2 or more and a nonzero pointer pulses `pth_valid` one cycle after `rsp_valid`. This first link is the one at `rsp_ptr`. Otherwise `pth_valid` stays low.
- R8: Writes through the `pw_*` port set a chain link's pattern, care mask, run count and next pointer. Links reset to all zeros. Pointer value 0 is the chain terminator.
- R9: In `ST_CHAIN`, `pth_step` without `lk_valid` has two outcomes. If the current link's next pointer is nonzero, the next cycle presents that link with `pth_valid`. If it is zero, `pth_end` pulses and the controller returns to `ST_IDLE`.
- R10: A lookup and an update in the same cycle leave the lookup seeing the updated entry. An update during `ST_TAG` delays the response by one cycle per update cycle.
- R11: `lk_ready` is high only in `ST_IDLE` and `ST_CHAIN`. A lookup presented while it is low is dropped. After reset, `lk_ready` is 1 and all pulse outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| br_valid | input | 1 | A conditional branch resolved this cycle |
| br_taken | input | 1 | Outcome of that branch |
| path_hist | output | 6 | Current branch history, newest outcome in bit 0 |
| lk_valid | input | 1 | Lookup request |
| lk_pc | input | 32 | Address of the branch being looked up |
| lk_ready | output | 1 | Controller can accept a lookup |
| up_valid | input | 1 | Loop-exit update |
| up_pc | input | 32 | Branch address of the exited loop |
| up_hist | input | 6 | History value saved when the loop was looked up |
| up_head | input | 32 | Observed loop head address |
| up_tail | input | 32 | Observed loop tail address |
| up_iters | input | 8 | Observed iteration count |
| up_ptr | input | 4 | Chain head to record |
| up_path_ok | input | 1 | The predicted first pattern was correct |
| pw_valid | input | 1 | Chain-link write |
| pw_idx | input | 4 | Link to write |
| pw_pat | input | 3 | Branch outcome pattern within one iteration |
| pw_care | input | 3 | 1 marks a pattern bit as meaningful |
| pw_cnt | input | 4 | Consecutive iterations following the pattern |
| pw_next | input | 4 | Next link, 0 ends the chain |
| pth_step | input | 1 | Request the next link of the chain |
| rsp_valid | output | 1 | Lookup response pulse |
| rsp_hit | output | 1 | Response is a tag hit |
| rsp_cache | output | 1 | Hand the loop to the loop cache |
| rsp_head | output | 32 | Predicted loop head |
| rsp_tail | output | 32 | Predicted loop tail |
| rsp_iters | output | 8 | Predicted iterations |
| rsp_ptr | output | 4 | Chain head pointer |
| rsp_conf | output | 2 | Confidence of the entry |
| pth_valid | output | 1 | A chain link is presented |
| pth_ptr | output | 4 | Index of the presented link |
| pth_pat | output | 3 | Link pattern |
| pth_care | output | 3 | Link care mask |
| pth_cnt | output | 4 | Link run count |
| pth_end | output | 1 | The chain has ended |

## Verification
The hardest case to reach is a confident multi-link chain walk. Confidence builds only through repeated matching updates to one entry. Those updates must carry the same history value that the later lookup will use. The chain links must also be written before the walk starts. The directed stimulus writes a three-link chain and installs one loop. It then trains that loop upward step by step, past saturation and back down, and walks the whole chain to its terminator. A second entry that aliases to the same index evicts the first, and the bench checks that confidence restarts from 0. A randomized phase over a few aliasing addresses then mixes lookups, updates, link writes and step requests in the same cycles, so that the update stall and the dropped-lookup paths occur many times.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_TAG   = 2'd1,
        ST_PATH  = 2'd2,
        ST_CHAIN = 2'd3
    } lpt_state_e;
endpackage

// File: rtl/lpt_history.sv
module lpt_history #(
    parameter int HIST_W = 6,
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 6,
    parameter int TAG_W  = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              taken,
    input  logic [ADDR_W-1:0] lk_pc,
    input  logic [ADDR_W-1:0] up_pc,
    input  logic [HIST_W-1:0] up_hist,
    output logic [HIST_W-1:0] hist,
    output logic [IDX_W-1:0]  lk_idx,
    output logic [TAG_W-1:0]  lk_tag,
    output logic [IDX_W-1:0]  up_idx,
    output logic [TAG_W-1:0]  up_tag
);
    logic [HIST_W-1:0] hist_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else if (shift_en) begin
            hist_q <= {hist_q[HIST_W-2:0], taken};
        end
    end

    assign hist = hist_q;

    // gshare-style fold: word-address bits XOR the zero-extended history
    assign lk_idx = lk_pc[IDX_W+1:2] ^ IDX_W'(hist_q);
    assign up_idx = up_pc[IDX_W+1:2] ^ IDX_W'(up_hist);

    // every address bit not used for the index goes into the tag
    assign lk_tag = {lk_pc[ADDR_W-1:IDX_W+2], lk_pc[1:0]};
    assign up_tag = {up_pc[ADDR_W-1:IDX_W+2], up_pc[1:0]};

    // R1
    hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> hist_q[0] == $past(taken) && hist_q[HIST_W-1:1] == $past(hist_q[HIST_W-2:0]));

    // R1
    hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(hist_q));
endmodule

// File: rtl/lpt_loop_table.sv
module lpt_loop_table #(
    parameter int ENTRIES = 64,
    parameter int IDX_W   = 6,
    parameter int TAG_W   = 26,
    parameter int ADDR_W  = 32,
    parameter int ITER_W  = 8,
    parameter int PTR_W   = 4,
    parameter int CONF_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [ADDR_W-1:0] wr_head,
    input  logic [ADDR_W-1:0] wr_tail,
    input  logic [ITER_W-1:0] wr_iters,
    input  logic [PTR_W-1:0]  wr_ptr,
    input  logic              wr_ok,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [ADDR_W-1:0] rd_head,
    output logic [ADDR_W-1:0] rd_tail,
    output logic [ITER_W-1:0] rd_iters,
    output logic [PTR_W-1:0]  rd_ptr,
    output logic [CONF_W-1:0] rd_conf
);
    localparam logic [CONF_W-1:0] CONF_MAX = '1;
    localparam logic [CONF_W-1:0] CONF_MIN = '0;

    logic              valid_q [ENTRIES];
    logic [TAG_W-1:0]  tag_q   [ENTRIES];
    logic [ADDR_W-1:0] head_q  [ENTRIES];
    logic [ADDR_W-1:0] tail_q  [ENTRIES];
    logic [ITER_W-1:0] iters_q [ENTRIES];
    logic [PTR_W-1:0]  ptr_q   [ENTRIES];
    logic [CONF_W-1:0] conf_q  [ENTRIES];

    logic              wr_match;
    logic [CONF_W-1:0] wr_conf;

    assign wr_match = valid_q[wr_idx] && (tag_q[wr_idx] == wr_tag);

    always_comb begin
        wr_conf = CONF_MIN;
        if (wr_match) begin
            if (wr_ok) begin
                wr_conf = (conf_q[wr_idx] == CONF_MAX) ? CONF_MAX : conf_q[wr_idx] + 1'b1;
            end else begin
                wr_conf = (conf_q[wr_idx] == CONF_MIN) ? CONF_MIN : conf_q[wr_idx] - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                valid_q[i] <= 1'b0;
            end
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx]   <= wr_tag;
            head_q[wr_idx]  <= wr_head;
            tail_q[wr_idx]  <= wr_tail;
            iters_q[wr_idx] <= wr_iters;
            ptr_q[wr_idx]   <= wr_ptr;
            conf_q[wr_idx]  <= wr_conf;
        end
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
    assign rd_head  = head_q[rd_idx];
    assign rd_tail  = tail_q[rd_idx];
    assign rd_iters = iters_q[rd_idx];
    assign rd_ptr   = ptr_q[rd_idx];
    assign rd_conf  = conf_q[rd_idx];

    // R6
    replace_conf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !wr_match |=> valid_q[$past(wr_idx)] && conf_q[$past(wr_idx)] == CONF_MIN);

    // R5
    conf_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_match && wr_ok && conf_q[wr_idx] == CONF_MAX |=> conf_q[$past(wr_idx)] == CONF_MAX);

    // R5
    conf_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_match && !wr_ok && conf_q[wr_idx] == CONF_MIN |=> conf_q[$past(wr_idx)] == CONF_MIN);
endmodule

// File: rtl/lpt_path_table.sv
module lpt_path_table #(
    parameter int PIL_ENTRIES = 16,
    parameter int PTR_W       = 4,
    parameter int PAT_W       = 3,
    parameter int PCNT_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_idx,
    input  logic [PAT_W-1:0]  wr_pat,
    input  logic [PAT_W-1:0]  wr_care,
    input  logic [PCNT_W-1:0] wr_cnt,
    input  logic [PTR_W-1:0]  wr_next,
    input  logic [PTR_W-1:0]  a_ptr,
    output logic [PAT_W-1:0]  a_pat,
    output logic [PAT_W-1:0]  a_care,
    output logic [PCNT_W-1:0] a_cnt,
    output logic [PTR_W-1:0]  a_next,
    input  logic [PTR_W-1:0]  b_ptr,
    output logic [PAT_W-1:0]  b_pat,
    output logic [PAT_W-1:0]  b_care,
    output logic [PCNT_W-1:0] b_cnt
);
    logic [PAT_W-1:0]  pat_q  [PIL_ENTRIES];
    logic [PAT_W-1:0]  care_q [PIL_ENTRIES];
    logic [PCNT_W-1:0] cnt_q  [PIL_ENTRIES];
    logic [PTR_W-1:0]  next_q [PIL_ENTRIES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < PIL_ENTRIES; i++) begin
                pat_q[i]  <= '0;
                care_q[i] <= '0;
                cnt_q[i]  <= '0;
                next_q[i] <= '0;
            end
        end else if (wr_en) begin
            pat_q[wr_idx]  <= wr_pat;
            care_q[wr_idx] <= wr_care;
            cnt_q[wr_idx]  <= wr_cnt;
            next_q[wr_idx] <= wr_next;
        end
    end

    // port a: current link and its successor pointer
    assign a_pat  = pat_q[a_ptr];
    assign a_care = care_q[a_ptr];
    assign a_cnt  = cnt_q[a_ptr];
    assign a_next = next_q[a_ptr];

    // port b: contents of the successor, read in the same cycle
    assign b_pat  = pat_q[b_ptr];
    assign b_care = care_q[b_ptr];
    assign b_cnt  = cnt_q[b_ptr];

    // R8
    link_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> next_q[$past(wr_idx)] == $past(wr_next) && pat_q[$past(wr_idx)] == $past(wr_pat));
endmodule

// File: rtl/loop_path_predictor.sv
module loop_path_predictor
    import lpt_pkg::*;
#(
    parameter int ENTRIES     = 64,
    parameter int HIST_W      = 6,
    parameter int ADDR_W      = 32,
    parameter int ITER_W      = 8,
    parameter int PIL_ENTRIES = 16,
    parameter int PAT_W       = 3,
    parameter int PCNT_W      = 4,
    parameter int CONF_W      = 2,
    localparam int IDX_W      = $clog2(ENTRIES),
    localparam int TAG_W      = ADDR_W - IDX_W,
    localparam int PTR_W      = $clog2(PIL_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              br_valid,
    input  logic              br_taken,
    output logic [HIST_W-1:0] path_hist,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_pc,
    output logic              lk_ready,
    input  logic              up_valid,
    input  logic [ADDR_W-1:0] up_pc,
    input  logic [HIST_W-1:0] up_hist,
    input  logic [ADDR_W-1:0] up_head,
    input  logic [ADDR_W-1:0] up_tail,
    input  logic [ITER_W-1:0] up_iters,
    input  logic [PTR_W-1:0]  up_ptr,
    input  logic              up_path_ok,
    input  logic              pw_valid,
    input  logic [PTR_W-1:0]  pw_idx,
    input  logic [PAT_W-1:0]  pw_pat,
    input  logic [PAT_W-1:0]  pw_care,
    input  logic [PCNT_W-1:0] pw_cnt,
    input  logic [PTR_W-1:0]  pw_next,
    input  logic              pth_step,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_cache,
    output logic [ADDR_W-1:0] rsp_head,
    output logic [ADDR_W-1:0] rsp_tail,
    output logic [ITER_W-1:0] rsp_iters,
    output logic [PTR_W-1:0]  rsp_ptr,
    output logic [CONF_W-1:0] rsp_conf,
    output logic              pth_valid,
    output logic [PTR_W-1:0]  pth_ptr,
    output logic [PAT_W-1:0]  pth_pat,
    output logic [PAT_W-1:0]  pth_care,
    output logic [PCNT_W-1:0] pth_cnt,
    output logic              pth_end
);
    localparam logic [CONF_W-1:0] CONF_GATE = CONF_W'(2);
    localparam logic [PTR_W-1:0]  NULL_PTR  = '0;
    localparam logic [ITER_W-1:0] ONE_ITER  = ITER_W'(1);

    lpt_state_e state, state_nx;

    logic [IDX_W-1:0]  lk_idx, up_idx, lk_idx_q;
    logic [TAG_W-1:0]  lk_tag, up_tag, lk_tag_q;
    logic [PTR_W-1:0]  cur_ptr;

    logic              tb_valid;
    logic [TAG_W-1:0]  tb_tag;
    logic [ADDR_W-1:0] tb_head, tb_tail;
    logic [ITER_W-1:0] tb_iters;
    logic [PTR_W-1:0]  tb_ptr;
    logic [CONF_W-1:0] tb_conf;

    logic [PAT_W-1:0]  a_pat, a_care, b_pat, b_care;
    logic [PCNT_W-1:0] a_cnt, b_cnt;
    logic [PTR_W-1:0]  a_next;

    logic tag_hit, go_path, lk_take, step_take;

    lpt_history #(
        .HIST_W(HIST_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W)
    ) u_hist (
        .clk(clk), .rst_n(rst_n), .shift_en(br_valid), .taken(br_taken),
        .lk_pc(lk_pc), .up_pc(up_pc), .up_hist(up_hist), .hist(path_hist),
        .lk_idx(lk_idx), .lk_tag(lk_tag), .up_idx(up_idx), .up_tag(up_tag)
    );

    lpt_loop_table #(
        .ENTRIES(ENTRIES), .IDX_W(IDX_W), .TAG_W(TAG_W), .ADDR_W(ADDR_W),
        .ITER_W(ITER_W), .PTR_W(PTR_W), .CONF_W(CONF_W)
    ) u_table (
        .clk(clk), .rst_n(rst_n), .wr_en(up_valid), .wr_idx(up_idx), .wr_tag(up_tag),
        .wr_head(up_head), .wr_tail(up_tail), .wr_iters(up_iters), .wr_ptr(up_ptr),
        .wr_ok(up_path_ok), .rd_idx(lk_idx_q), .rd_valid(tb_valid), .rd_tag(tb_tag),
        .rd_head(tb_head), .rd_tail(tb_tail), .rd_iters(tb_iters), .rd_ptr(tb_ptr),
        .rd_conf(tb_conf)
    );

    lpt_path_table #(
        .PIL_ENTRIES(PIL_ENTRIES), .PTR_W(PTR_W), .PAT_W(PAT_W), .PCNT_W(PCNT_W)
    ) u_links (
        .clk(clk), .rst_n(rst_n), .wr_en(pw_valid), .wr_idx(pw_idx), .wr_pat(pw_pat),
        .wr_care(pw_care), .wr_cnt(pw_cnt), .wr_next(pw_next),
        .a_ptr(cur_ptr), .a_pat(a_pat), .a_care(a_care), .a_cnt(a_cnt), .a_next(a_next),
        .b_ptr(a_next), .b_pat(b_pat), .b_care(b_care), .b_cnt(b_cnt)
    );

    assign tag_hit   = tb_valid && (tb_tag == lk_tag_q);
    assign go_path   = tag_hit && (tb_conf >= CONF_GATE) && (tb_ptr != NULL_PTR);
    assign lk_ready  = (state == ST_IDLE) || (state == ST_CHAIN);
    assign lk_take   = lk_valid && lk_ready;
    assign step_take = (state == ST_CHAIN) && !lk_valid && pth_step;

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (lk_valid) state_nx = ST_TAG;
            end
            ST_TAG: begin
                if (up_valid)     state_nx = ST_TAG;
                else if (go_path) state_nx = ST_PATH;
                else              state_nx = ST_IDLE;
            end
            ST_PATH: begin
                state_nx = ST_CHAIN;
            end
            ST_CHAIN: begin
                if (lk_valid)                              state_nx = ST_TAG;
                else if (pth_step && a_next == NULL_PTR)   state_nx = ST_IDLE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // request capture and chain cursor
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lk_idx_q <= '0;
            lk_tag_q <= '0;
            cur_ptr  <= NULL_PTR;
        end else begin
            if (lk_take) begin
                lk_idx_q <= lk_idx;
                lk_tag_q <= lk_tag;
            end
            if (state == ST_TAG && !up_valid && go_path) begin
                cur_ptr <= tb_ptr;
            end else if (step_take && a_next != NULL_PTR) begin
                cur_ptr <= a_next;
            end
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_cache <= 1'b0;
            rsp_head  <= '0;
            rsp_tail  <= '0;
            rsp_iters <= '0;
            rsp_ptr   <= '0;
            rsp_conf  <= '0;
            pth_valid <= 1'b0;
            pth_ptr   <= '0;
            pth_pat   <= '0;
            pth_care  <= '0;
            pth_cnt   <= '0;
            pth_end   <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            pth_valid <= 1'b0;
            pth_end   <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                end
                ST_TAG: begin
                    if (!up_valid) begin
                        rsp_valid <= 1'b1;
                        rsp_hit   <= tag_hit;
                        rsp_cache <= tag_hit && (tb_iters > ONE_ITER);
                        rsp_head  <= tag_hit ? tb_head  : '0;
                        rsp_tail  <= tag_hit ? tb_tail  : '0;
                        rsp_iters <= tag_hit ? tb_iters : '0;
                        rsp_ptr   <= tag_hit ? tb_ptr   : '0;
                        rsp_conf  <= tag_hit ? tb_conf  : '0;
                    end
                end
                ST_PATH: begin
                    pth_valid <= 1'b1;
                    pth_ptr   <= cur_ptr;
                    pth_pat   <= a_pat;
                    pth_care  <= a_care;
                    pth_cnt   <= a_cnt;
                end
                ST_CHAIN: begin
                    if (step_take) begin
                        if (a_next == NULL_PTR) begin
                            pth_end <= 1'b1;
                        end else begin
                            pth_valid <= 1'b1;
                            pth_ptr   <= a_next;
                            pth_pat   <= b_pat;
                            pth_care  <= b_care;
                            pth_cnt   <= b_cnt;
                        end
                    end
                end
            endcase
        end
    end

    // R4
    cache_handoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_cache |-> rsp_hit && rsp_iters > ONE_ITER);

    // R3
    miss_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_hit |-> !rsp_cache && rsp_iters == '0 && rsp_head == '0 && rsp_ptr == '0);

    // R7
    path_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_PATH |-> rsp_valid && rsp_hit && rsp_conf >= CONF_GATE && rsp_ptr != NULL_PTR);

    // R10
    upd_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_TAG && up_valid |=> state == ST_TAG && !rsp_valid);

    // R9
    end_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pth_end && pth_valid));

    // R11
    busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_PATH |=> state == ST_CHAIN);
endmodule

// File: tb/loop_path_predictor_tb.sv
module loop_path_predictor_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        br_valid = 0, br_taken = 0;
    logic [5:0]  path_hist;
    logic        lk_valid = 0;
    logic [31:0] lk_pc = '0;
    logic        lk_ready;
    logic        up_valid = 0;
    logic [31:0] up_pc = '0, up_head = '0, up_tail = '0;
    logic [5:0]  up_hist = '0;
    logic [7:0]  up_iters = '0;
    logic [3:0]  up_ptr = '0;
    logic        up_path_ok = 0;
    logic        pw_valid = 0;
    logic [3:0]  pw_idx = '0, pw_cnt = '0, pw_next = '0;
    logic [2:0]  pw_pat = '0, pw_care = '0;
    logic        pth_step = 0;
    logic        rsp_valid, rsp_hit, rsp_cache;
    logic [31:0] rsp_head, rsp_tail;
    logic [7:0]  rsp_iters;
    logic [3:0]  rsp_ptr;
    logic [1:0]  rsp_conf;
    logic        pth_valid, pth_end;
    logic [3:0]  pth_ptr, pth_cnt;
    logic [2:0]  pth_pat, pth_care;

    always #5 clk = ~clk;

    loop_path_predictor u_dut (
        .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_taken(br_taken),
        .path_hist(path_hist), .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_ready(lk_ready),
        .up_valid(up_valid), .up_pc(up_pc), .up_hist(up_hist), .up_head(up_head),
        .up_tail(up_tail), .up_iters(up_iters), .up_ptr(up_ptr), .up_path_ok(up_path_ok),
        .pw_valid(pw_valid), .pw_idx(pw_idx), .pw_pat(pw_pat), .pw_care(pw_care),
        .pw_cnt(pw_cnt), .pw_next(pw_next), .pth_step(pth_step),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_cache(rsp_cache),
        .rsp_head(rsp_head), .rsp_tail(rsp_tail), .rsp_iters(rsp_iters),
        .rsp_ptr(rsp_ptr), .rsp_conf(rsp_conf), .pth_valid(pth_valid),
        .pth_ptr(pth_ptr), .pth_pat(pth_pat), .pth_care(pth_care),
        .pth_cnt(pth_cnt), .pth_end(pth_end)
    );

    int n_chk = 0, n_err = 0, cyc = 0;
    bit chk_en = 0, done = 0;

    // behavioural reference: mode 0 waiting, 1 answering, 2 first link, 3 walking
    bit          m_v    [64];
    logic [25:0] m_tag  [64];
    logic [31:0] m_head [64], m_tail [64];
    int          m_it   [64], m_ptr [64], m_conf [64];
    int          p_pat  [16], p_care [16], p_cnt [16], p_next [16];
    int          m_hist, m_mode, m_lidx, m_cur, m_nmode, m_i, m_n;
    logic [25:0] m_ltag, m_t;
    bit          m_hit;
    bit          e_rv, e_hit, e_cache, e_pv, e_pe;
    logic [31:0] e_head, e_tail;
    int          e_it, e_ptr, e_conf, e_pptr, e_ppat, e_pcare, e_pcnt;

    function automatic int f_idx(input logic [31:0] pc, input int h);
        return ((pc >> 2) & 63) ^ (h & 63);
    endfunction
    function automatic logic [25:0] f_tag(input logic [31:0] pc);
        return {pc[31:8], pc[1:0]};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) m_v[i] = 0;
            for (int i = 0; i < 16; i++) begin
                p_pat[i] = 0; p_care[i] = 0; p_cnt[i] = 0; p_next[i] = 0;
            end
            m_hist = 0; m_mode = 0; m_cur = 0; m_lidx = 0; m_ltag = '0;
            e_rv = 0; e_hit = 0; e_cache = 0; e_head = '0; e_tail = '0;
            e_it = 0; e_ptr = 0; e_conf = 0; e_pv = 0; e_pe = 0;
            e_pptr = 0; e_ppat = 0; e_pcare = 0; e_pcnt = 0;
        end else begin
            e_rv = 0; e_pv = 0; e_pe = 0;
            m_nmode = m_mode;
            case (m_mode)
                0: if (lk_valid) begin
                    m_lidx = f_idx(lk_pc, m_hist); m_ltag = f_tag(lk_pc); m_nmode = 1;
                end
                1: if (!up_valid) begin
                    m_hit = m_v[m_lidx] && (m_tag[m_lidx] == m_ltag);
                    e_rv = 1; e_hit = m_hit;
                    e_head = m_hit ? m_head[m_lidx] : '0;
                    e_tail = m_hit ? m_tail[m_lidx] : '0;
                    e_it   = m_hit ? m_it[m_lidx] : 0;
                    e_ptr  = m_hit ? m_ptr[m_lidx] : 0;
                    e_conf = m_hit ? m_conf[m_lidx] : 0;
                    e_cache = m_hit && (e_it > 1);
                    if (m_hit && e_conf >= 2 && e_ptr != 0) begin
                        m_cur = e_ptr; m_nmode = 2;
                    end else m_nmode = 0;
                end
                2: begin
                    e_pv = 1; e_pptr = m_cur; e_ppat = p_pat[m_cur];
                    e_pcare = p_care[m_cur]; e_pcnt = p_cnt[m_cur]; m_nmode = 3;
                end
                default: begin
                    if (lk_valid) begin
                        m_lidx = f_idx(lk_pc, m_hist); m_ltag = f_tag(lk_pc); m_nmode = 1;
                    end else if (pth_step) begin
                        m_n = p_next[m_cur];
                        if (m_n == 0) begin
                            e_pe = 1; m_nmode = 0;
                        end else begin
                            e_pv = 1; e_pptr = m_n; e_ppat = p_pat[m_n];
                            e_pcare = p_care[m_n]; e_pcnt = p_cnt[m_n]; m_cur = m_n;
                        end
                    end
                end
            endcase
            if (up_valid) begin
                m_i = f_idx(up_pc, up_hist); m_t = f_tag(up_pc);
                if (m_v[m_i] && m_tag[m_i] == m_t)
                    m_conf[m_i] = up_path_ok ? ((m_conf[m_i] == 3) ? 3 : m_conf[m_i] + 1)
                                             : ((m_conf[m_i] == 0) ? 0 : m_conf[m_i] - 1);
                else m_conf[m_i] = 0;
                m_v[m_i] = 1; m_tag[m_i] = m_t; m_head[m_i] = up_head; m_tail[m_i] = up_tail;
                m_it[m_i] = up_iters; m_ptr[m_i] = up_ptr;
            end
            if (pw_valid) begin
                p_pat[pw_idx] = pw_pat; p_care[pw_idx] = pw_care;
                p_cnt[pw_idx] = pw_cnt; p_next[pw_idx] = pw_next;
            end
            if (br_valid) m_hist = ((m_hist << 1) | br_taken) & 63;
            m_mode = m_nmode;
        end
    end

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        if (chk_en && !done) begin
            chk("R1", "path_hist", path_hist, m_hist);
            chk("R11", "lk_ready", lk_ready, (m_mode == 0 || m_mode == 3));
            chk("R2", "rsp_valid", rsp_valid, e_rv);
            chk("R2", "rsp_hit", rsp_hit, e_hit);
            chk("R4", "rsp_cache", rsp_cache, e_cache);
            chk(e_hit ? "R5" : "R3", "rsp_head", rsp_head, e_head);
            chk(e_hit ? "R5" : "R3", "rsp_tail", rsp_tail, e_tail);
            chk(e_hit ? "R5" : "R3", "rsp_iters", rsp_iters, e_it);
            chk(e_hit ? "R5" : "R3", "rsp_ptr", rsp_ptr, e_ptr);
            chk("R6", "rsp_conf", rsp_conf, e_conf);
            chk("R7", "pth_valid", pth_valid, e_pv);
            chk("R8", "pth_ptr", pth_ptr, e_pptr);
            chk("R8", "pth_pat", pth_pat, e_ppat);
            chk("R8", "pth_care", pth_care, e_pcare);
            chk("R8", "pth_cnt", pth_cnt, e_pcnt);
            chk("R9", "pth_end", pth_end, e_pe);
        end
    end

    task automatic finish_up();
        done = 1;
        $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 200000 && !done) begin
            n_err++;
            $display("FAIL watchdog: actual=%0d cycles expected=done", cyc);
            finish_up();
        end
    end

    task automatic lookup(input logic [31:0] pc);
        lk_valid = 1; lk_pc = pc;
        @(negedge clk);
        lk_valid = 0;
    endtask

    task automatic update(input logic [31:0] pc, input int h, input logic [31:0] hd,
                          input logic [31:0] tl, input int it, input int p, input bit ok);
        up_valid = 1; up_pc = pc; up_hist = 6'(h); up_head = hd; up_tail = tl;
        up_iters = 8'(it); up_ptr = 4'(p); up_path_ok = ok;
        @(negedge clk);
        up_valid = 0;
    endtask

    task automatic link(input int i, input int pat, input int care, input int cnt, input int nx);
        pw_valid = 1; pw_idx = 4'(i); pw_pat = 3'(pat); pw_care = 3'(care);
        pw_cnt = 4'(cnt); pw_next = 4'(nx);
        @(negedge clk);
        pw_valid = 0;
    endtask

    task automatic step();
        pth_step = 1;
        @(negedge clk);
        pth_step = 0;
    endtask

    task automatic shift(input bit t);
        br_valid = 1; br_taken = t;
        @(negedge clk);
        br_valid = 0;
    endtask

    localparam logic [31:0] PA = 32'h0000_1234;
    localparam logic [31:0] PB = 32'h0000_1334;  // same index as PA, other tag
    localparam logic [31:0] PC = 32'h0040_2A10;

    initial begin
        repeat (3) @(negedge clk);
        chk_en = 1;
        // R11 reset state
        chk("R11", "reset lk_ready", lk_ready, 1);
        chk("R11", "reset rsp_valid", rsp_valid, 0);
        chk("R11", "reset path_hist", path_hist, 0);
        rst_n = 1;
        @(negedge clk);
        // R1 history shifting
        shift(1); shift(0); shift(1);
        repeat (2) @(negedge clk);
        // R3 miss on empty table
        lookup(PA); repeat (3) @(negedge clk);
        // R8 chain of three links
        link(1, 3'b001, 3'b111, 2, 2);
        link(2, 3'b000, 3'b111, 1, 3);
        link(3, 3'b100, 3'b100, 1, 0);
        // R6 install, confidence 0, hit without link
        update(PA, m_hist, 32'h2d24, 32'h2d68, 4, 1, 1);
        lookup(PA); repeat (3) @(negedge clk);
        // R5 train to 2, then R7 and R9 walk
        update(PA, m_hist, 32'h2d24, 32'h2d68, 4, 1, 1);
        update(PA, m_hist, 32'h2d24, 32'h2d68, 4, 1, 1);
        lookup(PA); repeat (3) @(negedge clk);
        step(); step(); step(); @(negedge clk);
        // R5 saturation and decrement
        repeat (4) update(PA, m_hist, 32'h2d24, 32'h2d68, 5, 1, 1);
        lookup(PA); repeat (3) @(negedge clk);
        step(); step(); step(); @(negedge clk);
        update(PA, m_hist, 32'h2d24, 32'h2d68, 5, 1, 0);
        lookup(PA); repeat (4) @(negedge clk);
        // R9 lookup while walking abandons the chain
        step(); lookup(PA); repeat (4) @(negedge clk);
        // R6 aliasing tag evicts and restarts confidence
        update(PB, m_hist, 32'h4000, 32'h4040, 1, 2, 1);
        lookup(PA); repeat (3) @(negedge clk);
        lookup(PB); repeat (3) @(negedge clk);   // R4 one iteration: no hand-off
        // R10 lookup and update together, then update during answer cycle
        lk_valid = 1; lk_pc = PC;
        update(PC, m_hist, 32'h8000, 32'h8020, 7, 3, 0);
        lk_valid = 0;
        repeat (3) @(negedge clk);
        lookup(PC);
        update(PC, m_hist, 32'h8100, 32'h8120, 9, 3, 1);
        lookup(PA);                                // R11 dropped while busy
        repeat (4) @(negedge clk);
        // randomized mix
        for (int k = 0; k < 3000; k++) begin
            logic [31:0] pcs [4];
            pcs[0] = PA; pcs[1] = PB; pcs[2] = PC; pcs[3] = PA ^ 32'h4;
            lk_valid = ($urandom_range(0, 3) == 0);
            lk_pc = pcs[$urandom_range(0, 3)];
            up_valid = ($urandom_range(0, 4) == 0);
            up_pc = pcs[$urandom_range(0, 3)];
            up_hist = ($urandom_range(0, 1) == 0) ? 6'(m_hist) : 6'($urandom);
            up_head = $urandom; up_tail = $urandom;
            up_iters = 8'($urandom_range(0, 6)); up_ptr = 4'($urandom_range(0, 4));
            up_path_ok = ($urandom_range(0, 3) != 0);
            pw_valid = ($urandom_range(0, 7) == 0);
            pw_idx = 4'($urandom_range(1, 5)); pw_pat = 3'($urandom); pw_care = 3'($urandom);
            pw_cnt = 4'($urandom); pw_next = 4'($urandom_range(0, 5));
            pth_step = ($urandom_range(0, 1) == 0);
            br_valid = ($urandom_range(0, 5) == 0); br_taken = 1'($urandom);
            @(negedge clk);
        end
        lk_valid = 0; up_valid = 0; pw_valid = 0; pth_step = 0; br_valid = 0;
        repeat (5) @(negedge clk);
        finish_up();
    end
endmodule